// File: doc/BRIEF.md
# Fourth-Order Cascaded Noise-Shaping Fractional Modulator

This block turns a constant 32-bit fractional word into a stream of small signed integers. The long-term mean of the stream equals the word divided by 2^32. It is meant to sit beside a programmable divider. On every enable strobe, typically one per divider output pulse, it produces the next signed correction to add to the integer divide ratio. Quantisation noise is pushed towards high frequencies, where a following loop filter removes it.

Internally it is a chain of first-order accumulators. The first stage adds the fractional word. Every later stage adds the freshly updated sum of the stage ahead of it. The overflow bit of each stage feeds a short shift line, one register per stage index. The current and delayed overflow bits are then combined with alternating binomial weights, so the higher stages contribute only differenced, high-pass noise. A parameter picks how many stages take part, from 1 to 4.

The first accumulator leaves reset holding 1 rather than 0. This seed breaks up the idle tones a zero-seeded cascade would produce for simple fractions. With four stages the output spans -7 to +8, so the default output word is 5 bits of two's complement.

Top module: `mash_sdm`

## Requirements
- R1: While reset is held, and after its release, the output is 0. The first accumulator starts at 1 and every other accumulator and overflow register starts at 0. For example, with the word 0xFFFFFFFF the first step after reset outputs exactly 1.
- R2: While the enable input is low, the output does not change and no internal state advances. After enable returns, the sequence continues as if the idle cycles had not happened.
- R3: On each step, stage 0 adds the fractional word modulo 2^32. Stage k adds the new sum of stage k-1. Each stage records its overflow (carry-out) bit for that step.
- R4: Stage k keeps its last k overflow bits in a shift line. On each step the line shifts before the new overflow bit enters, so delayed copy d holds the bit from d steps earlier.
- R5: With four stages, the output value is c0 + c1 - c1' + c2 - 2c2' + c2'' + c3 - 3c3' + 3c3'' - c3'''. Here ck is the overflow bit of stage k on this step, and each prime is one more step of delay.
- R6: With ORDER set below 4, the terms of stages numbered ORDER and above are left out. For ORDER=2 the output is c0 + c1 - c1'.
- R7: With four stages, the output is always between -7 and +8 inclusive. It is given as OUT_W-bit two's complement, 5 bits by default.
- R8: Over 65536 consecutive steps with a constant word F, the sum of the outputs stays within ±8 of F·65536/2^32.
- R9: The output is registered. The value for a step appears right after the rising clock edge at which the enable is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_en_i | input | 1 | Advances the modulator by one step when high at a rising edge |
| frac_i | input | ACC_W (32) | Fractional word; long-term mean is frac_i / 2^ACC_W |
| dq_o | output | OUT_W (5) | Signed two's-complement correction for the current step |

## Verification
Every cycle, the embedded properties check four things. Each accumulator advances by exactly its addend, with the overflow captured. Every shift line moves by one position per step. Nothing moves while the enable is low. The output stays within the weight-derived range. The exact output sequence, the effect of the reset seed, and the reduced-order formula depend on the data history, so only the bench scenarios show them. The same holds for the long-run mean, which the bench checks by comparing step by step against its own model of the cascade for both four-stage and two-stage instances.

// File: rtl/mash_pkg.sv
package mash_pkg;

  // n choose r, small arguments only
  function automatic int binom(input int n, input int r);
    int v;
    v = 1;
    for (int i = 0; i < r; i++) begin
      v = (v * (n - i)) / (i + 1);
    end
    return v;
  endfunction

  // weight of delayed copy j of stage k: coefficients of (1 - z^-1)^k
  function automatic int tap_weight(input int k, input int j);
    return ((j % 2) == 1) ? -binom(k, j) : binom(k, j);
  endfunction

  // largest reachable output for a given stage count
  function automatic int out_max(input int order);
    int s;
    s = 0;
    for (int k = 0; k < order; k++)
      for (int j = 0; j <= k; j++)
        if (tap_weight(k, j) > 0) s += tap_weight(k, j);
    return s;
  endfunction

  // smallest reachable output for a given stage count
  function automatic int out_min(input int order);
    int s;
    s = 0;
    for (int k = 0; k < order; k++)
      for (int j = 0; j <= k; j++)
        if (tap_weight(k, j) < 0) s += tap_weight(k, j);
    return s;
  endfunction

endpackage

// File: rtl/mash_stage.sv
module mash_stage #(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned DLY     = 0,
  parameter int unsigned TAP_W   = 4,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic [ACC_W-1:0] sum_o,
  output logic [TAP_W-1:0] taps_nxt_o
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [DLY:0]     tap_q, tap_d;
  logic [ACC_W:0]   wide;

  always_comb begin
    wide     = {1'b0, acc_q} + {1'b0, addend_i};
    acc_d    = wide[ACC_W-1:0];
    tap_d[0] = wide[ACC_W];
    for (int j = 1; j <= int'(DLY); j++) begin
      tap_d[j] = tap_q[j-1];
    end
  end

  assign sum_o      = acc_d;
  assign taps_nxt_o = TAP_W'(tap_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= ACC_W'(RST_VAL);
      tap_q <= '0;
    end else if (en_i) begin
      acc_q <= acc_d;
      tap_q <= tap_d;
    end
  end

  // R3: accumulator plus carry equals previous value plus addend
  a_r3_acc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ({tap_q[0], acc_q} == ($past({1'b0, acc_q}) + $past({1'b0, addend_i}))));

  // R2: no movement without a step
  a_r2_acc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(acc_q) && $stable(tap_q)));

  generate
    if (DLY > 0) begin : g_shift_chk
      // R4: each delayed copy takes the previous younger copy
      a_r4_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> (tap_q[DLY:1] == $past(tap_q[DLY-1:0])));
    end
  endgenerate

endmodule

// File: rtl/mash_combine.sv
module mash_combine
  import mash_pkg::*;
#(
  parameter int unsigned ORDER = 4,
  parameter int unsigned OUT_W = 5
) (
  input  logic [ORDER-1:0]        taps_i [ORDER],
  output logic signed [OUT_W-1:0] dq_o
);

  int total;

  always_comb begin
    total = 0;
    for (int k = 0; k < int'(ORDER); k++) begin
      for (int j = 0; j <= k; j++) begin
        if (taps_i[k][j]) total += tap_weight(k, j);
      end
    end
    dq_o = OUT_W'(total);
  end

endmodule

// File: rtl/mash_sdm.sv
module mash_sdm
  import mash_pkg::*;
#(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned ORDER = 4,
  parameter int unsigned OUT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_en_i,
  input  logic [ACC_W-1:0] frac_i,
  output logic [OUT_W-1:0] dq_o
);

  localparam int DQ_MAX = out_max(int'(ORDER));
  localparam int DQ_MIN = out_min(int'(ORDER));

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [ACC_W-1:0] sums     [ORDER];
  logic [ORDER-1:0] taps_nxt [ORDER];

  generate
    for (genvar k = 0; k < int'(ORDER); k++) begin : g_stage
      logic [ACC_W-1:0] addend;
      if (k == 0) begin : g_first
        assign addend = frac_i;
      end else begin : g_next
        assign addend = sums[k-1];
      end
      mash_stage #(
        .ACC_W  (ACC_W),
        .DLY    (k),
        .TAP_W  (ORDER),
        .RST_VAL((k == 0) ? 1 : 0)
      ) u_stage (
        .clk_i     (clk_i),
        .rst_ni    (rst_n_s),
        .en_i      (step_en_i),
        .addend_i  (addend),
        .sum_o     (sums[k]),
        .taps_nxt_o(taps_nxt[k])
      );
    end
  endgenerate

  logic signed [OUT_W-1:0] dq_d;
  logic        [OUT_W-1:0] dq_q;

  mash_combine #(
    .ORDER(ORDER),
    .OUT_W(OUT_W)
  ) u_combine (
    .taps_i(taps_nxt),
    .dq_o  (dq_d)
  );

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s)       dq_q <= '0;
    else if (step_en_i) dq_q <= dq_d;
  end

  assign dq_o = dq_q;

  // R2: output frozen between steps
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !step_en_i |=> $stable(dq_o));

  // R7: output within the weight-derived range
  a_r7_range: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (($signed(dq_o) >= DQ_MIN) && ($signed(dq_o) <= DQ_MAX)));

  // R9: registered output takes the combined value of the sampled step
  a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    step_en_i |=> (dq_o == $past(dq_d)));

  // R1: output is zero in the first cycle after reset release
  a_r1_reset_out: assert property (@(posedge clk_i)
    $rose(rst_n_s) |-> (dq_o == '0));

endmodule

// File: tb/mash_sdm_tb.sv
module mash_sdm_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [31:0] frac;
  logic [4:0]  dq4;
  logic [4:0]  dq2;

  int n_checks;
  int n_fails;

  // model state: [instance][stage], [instance][stage][delay]
  longint unsigned m_acc [2][4];
  bit              m_c   [2][4][4];
  int              m_exp [2];

  mash_sdm #(.ACC_W(32), .ORDER(4), .OUT_W(5)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .step_en_i(en), .frac_i(frac), .dq_o(dq4));

  mash_sdm #(.ACC_W(32), .ORDER(2), .OUT_W(5)) u_dut_o2 (
    .clk_i(clk), .rst_ni(rst_n), .step_en_i(en), .frac_i(frac), .dq_o(dq2));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 4; k++) begin
        m_acc[m][k] = (k == 0) ? 64'd1 : 64'd0;
        for (int d = 0; d < 4; d++) m_c[m][k][d] = 1'b0;
      end
      m_exp[m] = 0;
    end
  endtask

  task automatic model_step(input logic [31:0] f);
    for (int m = 0; m < 2; m++) begin
      longint unsigned add;
      longint unsigned s;
      int o;
      for (int k = 0; k < 4; k++)
        for (int d = 3; d > 0; d--) m_c[m][k][d] = m_c[m][k][d-1];
      add = {32'd0, f};
      for (int k = 0; k < 4; k++) begin
        s = m_acc[m][k] + add;
        m_c[m][k][0] = s[32];
        m_acc[m][k] = {32'd0, s[31:0]};
        add = m_acc[m][k];
      end
      o = int'(m_c[m][0][0]) + int'(m_c[m][1][0]) - int'(m_c[m][1][1]);
      if (m == 0) begin
        o += int'(m_c[m][2][0]) - 2*int'(m_c[m][2][1]) + int'(m_c[m][2][2])
           + int'(m_c[m][3][0]) - 3*int'(m_c[m][3][1]) + 3*int'(m_c[m][3][2])
           - int'(m_c[m][3][3]);
      end
      m_exp[m] = o;
    end
  endtask

  function automatic int s5(input logic [4:0] v);
    return int'($signed(v));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out during reset", s5(dq4), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out after release", s5(dq4), 0);
    check("R1 order2 out after release", s5(dq2), 0);
    model_reset();
  endtask

  // n steps back to back, each compared against the model
  task automatic run_steps(input logic [31:0] f, input int n, input string tag,
                           output longint sum);
    int lo, hi;
    sum = 0;
    lo = 100;
    hi = -100;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check({tag, " R5 step"}, s5(dq4), m_exp[0]);
        check({tag, " R6 order2 step"}, s5(dq2), m_exp[1]);
        sum += s5(dq4);
        if (s5(dq4) < lo) lo = s5(dq4);
        if (s5(dq4) > hi) hi = s5(dq4);
      end
      en = 1'b1;
      frac = f;
      model_step(f);
    end
    @(negedge clk);
    en = 1'b0;
    check({tag, " R9 last step"}, s5(dq4), m_exp[0]);
    check({tag, " R6 order2 last"}, s5(dq2), m_exp[1]);
    sum += s5(dq4);
    if (s5(dq4) < lo) lo = s5(dq4);
    if (s5(dq4) > hi) hi = s5(dq4);
    check({tag, " R7 low bound"}, int'(lo >= -7), 1);
    check({tag, " R7 high bound"}, int'(hi <= 8), 1);
  endtask

  task automatic t_seed();
    longint s;
    do_reset();
    run_steps(32'hFFFF_FFFF, 1, "seed", s);
    check("R1 seed gives carry on first step", s5(dq4), 1);
  endtask

  task automatic t_patterns();
    longint s;
    do_reset();
    run_steps(32'h0000_0000, 40, "zero R3", s);
    check("R3 zero word sums to zero", int'(s), 0);
    run_steps(32'h8000_0000, 200, "half R4", s);
    run_steps(32'h0000_0001, 200, "tiny R3", s);
    run_steps(32'hFFFF_FFFF, 200, "full R4", s);
    run_steps(32'h5555_5555, 300, "alt R5", s);
    run_steps(32'h1234_5678, 300, "mixed R5", s);
  endtask

  task automatic t_hold();
    longint s;
    int held;
    do_reset();
    run_steps(32'h3C3C_1A2B, 57, "pre-hold", s);
    held = s5(dq4);
    @(negedge clk);
    frac = 32'h7777_7777;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R2 output held while idle", s5(dq4), held);
    end
    run_steps(32'h3C3C_1A2B, 120, "post-hold R2", s);
  endtask

  task automatic t_mean(input logic [31:0] f);
    longint s;
    longint exp_sum;
    longint diff;
    do_reset();
    run_steps(f, 65536, "mean", s);
    exp_sum = longint'((64'(f) * 64'd65536) >> 32);
    diff = s - exp_sum;
    if (diff < 0) diff = -diff;
    n_checks++;
    if (diff > 8) begin
      n_fails++;
      $display("FAIL R8 mean: actual %0d expected %0d", s, exp_sum);
    end
  endtask

  task automatic t_midreset();
    longint s;
    run_steps(32'h0F0F_F0F0, 33, "before reset", s);
    do_reset();
    run_steps(32'hFFFF_FFFF, 1, "after reset", s);
    check("R1 seed after mid-run reset", s5(dq4), 1);
    run_steps(32'h0F0F_F0F0, 100, "after reset R4", s);
  endtask

  initial begin
    n_checks = 0;
    n_fails = 0;
    rst_n = 1'b0;
    en = 1'b0;
    frac = '0;
    model_reset();
    t_seed();
    t_patterns();
    t_hold();
    t_midreset();
    t_mean(32'h2AAA_AAAB);
    t_mean(32'hC000_1234);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule